// File: doc/BRIEF.md
# Disk Controller Command and Status Registers

This block holds the two 16-bit control and status words of a controller that sits between a host bus and a set of up to eight storage drives. The host reaches the words through a word-addressed write port with two byte-lane enables. Both words are readable at all times on dedicated read outputs. The first word carries the command function, the GO bit, interrupt enable, ready, an error summary, drive status and two upper address bits. The second word carries the unit number, transfer modifiers and the fine-grained error flags.

The drive side reports through a status strobe. The strobe comes with completion, attention, error, available and nonexistent-drive qualifiers. The drive side receives a one-cycle command strobe with the six command bits, a one-cycle unit-select strobe when the unit number changes, and a one-cycle reset pulse when the host requests a controller clear. A start-of-transfer pulse from the data path drops ready. An interrupt request is raised on completion or on demand by the program, and it is held until the host acknowledges it.

Top module: `dsk_csr_ctl`

## Requirements
- R1: After reset, and in the cycle after a `bus_init` pulse, word 1 reads 0x0080 (only ready, bit 7), word 2 reads 0x0000, and `irq_req` is 0.
- R2: A word 1 write with lane 1 (`wr_be[1]`) loads address-extension bits 9:8 from data bits 9:8. Bits 15, 13, 12, 11 and 10 are not affected by such a write. A write with neither lane enabled changes nothing.
- R3: A word 1 write with lane 0 (`wr_be[0]`) loads interrupt enable (bit 6), the function (bits 5:1) and GO (bit 0), but not ready. In the next cycle `cmd_stb` is 1 for one cycle and `cmd_code` equals data bits 5:0. A lane-1-only write gives no `cmd_stb`.
- R4: A word 1 lane-0 write with data bits 7 and 6 both 1 raises `irq_req` in the next cycle.
- R5: A status strobe updates attention (bit 15), transfer error (bit 14) and drive available (bit 11) from its qualifiers. With completion it also clears GO and sets ready.
- R6: A completing status strobe, with interrupt enable set and either attention or ready currently 0, raises `irq_req` and clears interrupt enable. With ready already 1 and no attention it raises nothing, and interrupt enable stays set.
- R7: Once raised, `irq_req` stays 1 until a cycle with `irq_ack` high.
- R8: An `xfer_start` pulse clears ready, unless a completing status arrives in the same cycle.
- R9: A word 1 lane-1 write with data bit 14 set clears transfer error, word 2 data parity error (bit 13) and nonexistent drive (bit 12).
- R10: Word 2 lane 0 loads unit (bits 2:0), increment inhibit (bit 3) and parity test (bit 4). Lane 1 loads data parity error (bit 13). Bits 12, 11, 10, 7 and 6 are never written.
- R11: A unit value different from the current one gives a one-cycle `unit_stb` in the next cycle, with `unit_sel` showing the new unit. Rewriting the same unit gives no strobe.
- R12: A word 2 lane-0 write with bit 5 set clears interrupt enable and nonexistent drive. It gives a one-cycle `drv_clear` in the next cycle, and bit 5 always reads 0.
- R13: A status strobe arriving while `drv_clear` is high leaves nonexistent drive unchanged. At any other time the strobe's nonexistent-drive qualifier is copied into bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous return of both words to reset values |
| wr_en | input | 1 | Host write cycle |
| wr_sel | input | 1 | Word select: 0 word 1, 1 word 2 |
| wr_be | input | 2 | Byte-lane enables, bit 1 high byte |
| wr_data | input | 16 | Host write data |
| cs1_rdata | output | 16 | Word 1 read value |
| cs2_rdata | output | 16 | Word 2 read value |
| drv_stat_vld | input | 1 | Drive status strobe |
| drv_done | input | 1 | Status qualifier: command complete |
| drv_attn | input | 1 | Status qualifier: attention |
| drv_err | input | 1 | Status qualifier: error |
| drv_avail | input | 1 | Status qualifier: drive available |
| drv_ned | input | 1 | Status qualifier: nonexistent drive |
| xfer_start | input | 1 | Data transfer started |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| cmd_stb | output | 1 | Command strobe to drives |
| cmd_code | output | 6 | Command bits sent with cmd_stb |
| unit_stb | output | 1 | Unit selection changed |
| unit_sel | output | 3 | Selected unit |
| drv_clear | output | 1 | Reset pulse to all drives |

## Verification
The word read-back is tried with writes on each lane alone, on both lanes, and with no lane enabled. This shows that every field sits in the correct lane and that unwritable bits hold. The interrupt path is tried with completion after a transfer start, completion with ready already set, completion with attention, and a program-forced request. This separates the ready-edge cause from the attention cause from the forced cause. The clear is followed at once by a status strobe that carries the nonexistent-drive flag. A second strobe one cycle later shows that the flag is blocked only during the clear.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int WORD_W  = 16;
  localparam int FUNC_W  = 5;
  localparam int AEXT_W  = 2;
  localparam int UNIT_W  = 3;
  localparam int CMD_W   = FUNC_W + 1;

  // word 1 positions
  localparam int W1_ATTN = 15;
  localparam int W1_TERR = 14;
  localparam int W1_AVL  = 11;
  localparam int W1_AEXT = 8;
  localparam int W1_RDY  = 7;
  localparam int W1_IE   = 6;
  localparam int W1_FUNC = 1;
  localparam int W1_GO   = 0;

  // word 2 positions
  localparam int W2_DPE  = 13;
  localparam int W2_NED  = 12;
  localparam int W2_NXM  = 11;
  localparam int W2_PGE  = 10;
  localparam int W2_OR   = 7;
  localparam int W2_IR   = 6;
  localparam int W2_CLR  = 5;
  localparam int W2_PTST = 4;
  localparam int W2_INH  = 3;
  localparam int W2_UNIT = 0;

  typedef struct packed {
    logic vld;
    logic done;
    logic attn;
    logic err;
    logic avail;
    logic ned;
  } drv_stat_t;
endpackage

// File: rtl/dcsr_irq.sv
module dcsr_irq
  import dcsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      init,
  input  logic      ld_lo,
  input  logic      wr_rdy,
  input  logic      wr_ie,
  input  drv_stat_t stat,
  input  logic      rdy_q,
  input  logic      ie_q,
  input  logic      ack,
  output logic      ie_take,
  output logic      irq_req
);
  logic irq_q, irq_d;
  logic forced;

  always_comb begin
    forced  = ld_lo & wr_rdy & wr_ie;
    ie_take = stat.vld & stat.done & ie_q & (stat.attn | ~rdy_q);
    irq_d   = irq_q;
    if (ack)
      irq_d = 1'b0;
    if (forced | ie_take)
      irq_d = 1'b1;
    if (init)
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_req = irq_q;
endmodule

// File: rtl/dcsr_cs1.sv
module dcsr_cs1
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [WORD_W-1:0] wdata,
  input  drv_stat_t         stat,
  input  logic              xfer_start,
  input  logic              ie_take,
  input  logic              ie_clr,
  output logic [WORD_W-1:0] rdata,
  output logic              rdy_o,
  output logic              ie_o,
  output logic              err_wipe,
  output logic              cmd_stb,
  output logic [CMD_W-1:0]  cmd_code
);
  logic              attn_q, attn_d;
  logic              terr_q, terr_d;
  logic              avl_q, avl_d;
  logic [AEXT_W-1:0] aext_q, aext_d;
  logic              rdy_q, rdy_d;
  logic              ie_q, ie_d;
  logic [FUNC_W-1:0] func_q, func_d;
  logic              go_q, go_d;
  logic              stb_q, stb_d;
  logic [CMD_W-1:0]  code_q, code_d;

  assign err_wipe = ld_hi & wdata[W1_TERR];

  always_comb begin
    attn_d = attn_q;
    terr_d = terr_q;
    avl_d  = avl_q;
    aext_d = aext_q;
    rdy_d  = rdy_q;
    ie_d   = ie_q;
    func_d = func_q;
    go_d   = go_q;
    stb_d  = ld_lo;
    code_d = code_q;

    if (xfer_start)
      rdy_d = 1'b0;
    if (stat.vld) begin
      attn_d = stat.attn;
      terr_d = stat.err;
      avl_d  = stat.avail;
      if (stat.done) begin
        go_d  = 1'b0;
        rdy_d = 1'b1;
      end
    end
    if (ie_take | ie_clr)
      ie_d = 1'b0;
    if (ld_hi) begin
      aext_d = wdata[W1_AEXT +: AEXT_W];
      if (wdata[W1_TERR])
        terr_d = 1'b0;
    end
    if (ld_lo) begin
      ie_d   = wdata[W1_IE];
      func_d = wdata[W1_FUNC +: FUNC_W];
      go_d   = wdata[W1_GO];
      code_d = wdata[CMD_W-1:0];
    end
    if (init) begin
      attn_d = 1'b0;
      terr_d = 1'b0;
      avl_d  = 1'b0;
      aext_d = '0;
      rdy_d  = 1'b1;
      ie_d   = 1'b0;
      func_d = '0;
      go_d   = 1'b0;
      stb_d  = 1'b0;
      code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attn_q <= 1'b0;
      terr_q <= 1'b0;
      avl_q  <= 1'b0;
      aext_q <= '0;
      rdy_q  <= 1'b1;
      ie_q   <= 1'b0;
      func_q <= '0;
      go_q   <= 1'b0;
      stb_q  <= 1'b0;
      code_q <= '0;
    end else begin
      attn_q <= attn_d;
      terr_q <= terr_d;
      avl_q  <= avl_d;
      aext_q <= aext_d;
      rdy_q  <= rdy_d;
      ie_q   <= ie_d;
      func_q <= func_d;
      go_q   <= go_d;
      stb_q  <= stb_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[W1_ATTN]              = attn_q;
    rdata[W1_TERR]              = terr_q;
    rdata[W1_AVL]               = avl_q;
    rdata[W1_AEXT +: AEXT_W]    = aext_q;
    rdata[W1_RDY]               = rdy_q;
    rdata[W1_IE]                = ie_q;
    rdata[W1_FUNC +: FUNC_W]    = func_q;
    rdata[W1_GO]                = go_q;
  end

  assign rdy_o    = rdy_q;
  assign ie_o     = ie_q;
  assign cmd_stb  = stb_q;
  assign cmd_code = code_q;
endmodule

// File: rtl/dcsr_cs2.sv
module dcsr_cs2
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [WORD_W-1:0] wdata,
  input  drv_stat_t         stat,
  input  logic              err_wipe,
  output logic [WORD_W-1:0] rdata,
  output logic              ie_clr,
  output logic              drv_clear,
  output logic              unit_stb,
  output logic [UNIT_W-1:0] unit_sel
);
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic              inh_q, inh_d;
  logic              ptst_q, ptst_d;
  logic              dpe_q, dpe_d;
  logic              ned_q, ned_d;
  logic              clr_q, clr_d;
  logic              ustb_q, ustb_d;

  assign ie_clr = ld_lo & wdata[W2_CLR];

  always_comb begin
    unit_d = unit_q;
    inh_d  = inh_q;
    ptst_d = ptst_q;
    dpe_d  = dpe_q;
    ned_d  = ned_q;
    clr_d  = ie_clr;
    ustb_d = 1'b0;

    if (stat.vld && !clr_q)
      ned_d = stat.ned;
    if (err_wipe) begin
      dpe_d = 1'b0;
      ned_d = 1'b0;
    end
    if (ld_hi)
      dpe_d = wdata[W2_DPE];
    if (ld_lo) begin
      unit_d = wdata[W2_UNIT +: UNIT_W];
      inh_d  = wdata[W2_INH];
      ptst_d = wdata[W2_PTST];
      ustb_d = (wdata[W2_UNIT +: UNIT_W] != unit_q);
      if (wdata[W2_CLR])
        ned_d = 1'b0;
    end
    if (init) begin
      unit_d = '0;
      inh_d  = 1'b0;
      ptst_d = 1'b0;
      dpe_d  = 1'b0;
      ned_d  = 1'b0;
      clr_d  = 1'b0;
      ustb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q <= '0;
      inh_q  <= 1'b0;
      ptst_q <= 1'b0;
      dpe_q  <= 1'b0;
      ned_q  <= 1'b0;
      clr_q  <= 1'b0;
      ustb_q <= 1'b0;
    end else begin
      unit_q <= unit_d;
      inh_q  <= inh_d;
      ptst_q <= ptst_d;
      dpe_q  <= dpe_d;
      ned_q  <= ned_d;
      clr_q  <= clr_d;
      ustb_q <= ustb_d;
    end
  end

  // nonexistent memory, program error and the two buffer-ready flags
  // have no source inside this block and read as zero
  always_comb begin
    rdata                    = '0;
    rdata[W2_DPE]            = dpe_q;
    rdata[W2_NED]            = ned_q;
    rdata[W2_PTST]           = ptst_q;
    rdata[W2_INH]            = inh_q;
    rdata[W2_UNIT +: UNIT_W] = unit_q;
  end

  assign drv_clear = clr_q;
  assign unit_stb  = ustb_q;
  assign unit_sel  = unit_q;
endmodule

// File: rtl/dsk_csr_ctl.sv
module dsk_csr_ctl
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cs1_rdata,
  output logic [WORD_W-1:0] cs2_rdata,
  input  logic              drv_stat_vld,
  input  logic              drv_done,
  input  logic              drv_attn,
  input  logic              drv_err,
  input  logic              drv_avail,
  input  logic              drv_ned,
  input  logic              xfer_start,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic              cmd_stb,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              unit_stb,
  output logic [UNIT_W-1:0] unit_sel,
  output logic              drv_clear
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       w1_hi, w1_lo, w2_hi, w2_lo;
  logic       rdy_q, ie_q, ie_take, ie_clr, err_wipe;
  drv_stat_t  stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    w1_hi = wr_en & ~wr_sel & wr_be[1] & ~bus_init;
    w1_lo = wr_en & ~wr_sel & wr_be[0] & ~bus_init;
    w2_hi = wr_en &  wr_sel & wr_be[1] & ~bus_init;
    w2_lo = wr_en &  wr_sel & wr_be[0] & ~bus_init;
    stat  = '{vld: drv_stat_vld, done: drv_done, attn: drv_attn,
              err: drv_err, avail: drv_avail, ned: drv_ned};
  end

  dcsr_cs1 u_cs1 (
    .clk(clk), .rst_n(rst_s_n), .init(bus_init),
    .ld_hi(w1_hi), .ld_lo(w1_lo), .wdata(wr_data),
    .stat(stat), .xfer_start(xfer_start),
    .ie_take(ie_take), .ie_clr(ie_clr),
    .rdata(cs1_rdata), .rdy_o(rdy_q), .ie_o(ie_q),
    .err_wipe(err_wipe), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
  );

  dcsr_cs2 u_cs2 (
    .clk(clk), .rst_n(rst_s_n), .init(bus_init),
    .ld_hi(w2_hi), .ld_lo(w2_lo), .wdata(wr_data),
    .stat(stat), .err_wipe(err_wipe),
    .rdata(cs2_rdata), .ie_clr(ie_clr), .drv_clear(drv_clear),
    .unit_stb(unit_stb), .unit_sel(unit_sel)
  );

  dcsr_irq u_irq (
    .clk(clk), .rst_n(rst_s_n), .init(bus_init),
    .ld_lo(w1_lo), .wr_rdy(wr_data[W1_RDY]), .wr_ie(wr_data[W1_IE]),
    .stat(stat), .rdy_q(rdy_q), .ie_q(ie_q), .ack(irq_ack),
    .ie_take(ie_take), .irq_req(irq_req)
  );
endmodule

// File: rtl/dcsr_chk.sv
module dcsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_init,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [1:0]  wr_be,
  input logic [15:0] cs1_rdata,
  input logic [15:0] cs2_rdata,
  input logic        drv_stat_vld,
  input logic        drv_done,
  input logic        xfer_start,
  input logic        irq_req,
  input logic        irq_ack,
  input logic        cmd_stb,
  input logic        unit_stb,
  input logic [2:0]  unit_sel,
  input logic        drv_clear
);
  // R1
  init_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (cs1_rdata == 16'h0080 && cs2_rdata == 16'h0000 && !irq_req));

  // R3
  cmd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_be[0] && !bus_init) |=> cmd_stb);

  // R3
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel && wr_be[0]) |=> !cmd_stb);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && !bus_init) |=> irq_req);

  // R8
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !bus_init && !(drv_stat_vld && drv_done)) |=> !cs1_rdata[7]);

  // R11
  unit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_stb |-> unit_sel != $past(unit_sel));

  // R12
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_clear |=> !drv_clear);

  // R12
  clear_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs2_rdata[5]);
endmodule

bind dsk_csr_ctl dcsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_be(wr_be), .cs1_rdata(cs1_rdata),
  .cs2_rdata(cs2_rdata), .drv_stat_vld(drv_stat_vld), .drv_done(drv_done),
  .xfer_start(xfer_start), .irq_req(irq_req), .irq_ack(irq_ack),
  .cmd_stb(cmd_stb), .unit_stb(unit_stb), .unit_sel(unit_sel),
  .drv_clear(drv_clear)
);

// File: tb/sim_dsk_csr_ctl.sv
module sim_dsk_csr_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] cs1_rdata, cs2_rdata;
  logic        drv_stat_vld = 1'b0, drv_done = 1'b0, drv_attn = 1'b0;
  logic        drv_err = 1'b0, drv_avail = 1'b0, drv_ned = 1'b0;
  logic        xfer_start = 1'b0, irq_ack = 1'b0;
  logic        irq_req, cmd_stb, unit_stb, drv_clear;
  logic [5:0]  cmd_code;
  logic [2:0]  unit_sel;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dsk_csr_ctl u0 (.*);

  // {sel, be[1:0], data, exp word1, exp word2}
  localparam logic [50:0] VEC [8] = '{
    {1'b0, 2'b10, 16'hFFFF, 16'h0380, 16'h0000},
    {1'b0, 2'b01, 16'h003E, 16'h03BE, 16'h0000},
    {1'b0, 2'b11, 16'h0105, 16'h0185, 16'h0000},
    {1'b1, 2'b01, 16'h001D, 16'h0185, 16'h001D},
    {1'b1, 2'b10, 16'hFFFF, 16'h0185, 16'h201D},
    {1'b1, 2'b11, 16'h0002, 16'h0185, 16'h0002},
    {1'b0, 2'b00, 16'hFFFF, 16'h0185, 16'h0002},
    {1'b0, 2'b10, 16'h0000, 16'h0085, 16'h0002}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic st(input logic dn, input logic at, input logic er,
                    input logic av, input logic nd);
    @(negedge clk);
    drv_stat_vld = 1'b1; drv_done = dn; drv_attn = at;
    drv_err = er; drv_avail = av; drv_ned = nd;
    @(negedge clk);
    drv_stat_vld = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word1 after reset", cs1_rdata, 16'h0080);
    chk("R1 word2 after reset", cs2_rdata, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq_req}, 16'h0);

    // R2 R3 R10: field placement per lane
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][50], VEC[i][49:48], VEC[i][47:32]);
      chk("R2/R3 word1 table", cs1_rdata, VEC[i][31:16]);
      chk("R10 word2 table", cs2_rdata, VEC[i][15:0]);
    end

    // R3 command strobe
    wr(1'b0, 2'b01, 16'h0013);
    chk("R3 cmd_stb", {15'b0, cmd_stb}, 16'h1);
    chk("R3 cmd_code", {10'b0, cmd_code}, 16'h0013);
    @(negedge clk);
    chk("R3 cmd_stb single cycle", {15'b0, cmd_stb}, 16'h0);
    wr(1'b0, 2'b10, 16'h0000);
    chk("R3 no strobe on high lane", {15'b0, cmd_stb}, 16'h0);

    // R8 then R5
    pulse_xfer();
    chk("R8 ready dropped", cs1_rdata, 16'h0013);
    st(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 completion status", cs1_rdata, 16'h4892);
    chk("R6 no irq with IE clear", {15'b0, irq_req}, 16'h0);

    // R9 error wipe
    wr(1'b1, 2'b10, 16'h2000);
    st(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 setup word2", cs2_rdata, 16'h3002);
    wr(1'b0, 2'b10, 16'h4000);
    chk("R9 word1 error cleared", cs1_rdata, 16'h0892);
    chk("R9 word2 errors cleared", cs2_rdata, 16'h0002);

    // R6 ready-edge interrupt, R7 hold
    wr(1'b0, 2'b01, 16'h0043);
    chk("R4 no forced irq without bit7", {15'b0, irq_req}, 16'h0);
    pulse_xfer();
    st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 irq on ready edge", {15'b0, irq_req}, 16'h1);
    chk("R6 IE and GO cleared", cs1_rdata, 16'h0882);
    repeat (3) @(negedge clk);
    chk("R7 irq held", {15'b0, irq_req}, 16'h1);
    pulse_ack();
    chk("R7 irq released by ack", {15'b0, irq_req}, 16'h0);

    // R6 no interrupt when already ready, then attention
    wr(1'b0, 2'b01, 16'h0040);
    st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 no irq already ready", {15'b0, irq_req}, 16'h0);
    chk("R6 IE kept", cs1_rdata, 16'h08C0);
    st(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 irq on attention", {15'b0, irq_req}, 16'h1);
    chk("R5 attention shown", cs1_rdata, 16'h8880);
    pulse_ack();

    // R4 forced interrupt
    wr(1'b0, 2'b01, 16'h00C0);
    chk("R4 forced irq", {15'b0, irq_req}, 16'h1);
    chk("R4 word1", cs1_rdata, 16'h88C0);
    pulse_ack();

    // R11 unit strobe
    wr(1'b1, 2'b01, 16'h0002);
    chk("R11 same unit no strobe", {15'b0, unit_stb}, 16'h0);
    wr(1'b1, 2'b01, 16'h0006);
    chk("R11 unit strobe", {15'b0, unit_stb}, 16'h1);
    chk("R11 unit value", {13'b0, unit_sel}, 16'h0006);

    // R12 R13 controller clear
    st(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 ned follows status", cs2_rdata, 16'h1006);
    wr(1'b1, 2'b01, 16'h0026);
    chk("R12 drv_clear pulse", {15'b0, drv_clear}, 16'h1);
    chk("R12 word2 after clear", cs2_rdata, 16'h0006);
    chk("R12 IE cleared", cs1_rdata, 16'h0880);
    drv_stat_vld = 1'b1; drv_done = 1'b0; drv_attn = 1'b0;
    drv_err = 1'b0; drv_avail = 1'b1; drv_ned = 1'b1;
    @(negedge clk);
    drv_stat_vld = 1'b0;
    chk("R13 ned blocked during clear", cs2_rdata, 16'h0006);
    chk("R12 drv_clear single cycle", {15'b0, drv_clear}, 16'h0);
    st(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 ned after clear", cs2_rdata, 16'h1006);

    // R1 bus init
    wr(1'b0, 2'b01, 16'h00C0);
    @(negedge clk); bus_init = 1'b1;
    @(negedge clk); bus_init = 1'b0;
    chk("R1 word1 after init", cs1_rdata, 16'h0080);
    chk("R1 word2 after init", cs2_rdata, 16'h0000);
    chk("R1 irq after init", {15'b0, irq_req}, 16'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule